// File: doc/BRIEF.md
# Error Record Update Engine

This block is the logic behind one error record. A hardware unit presents error reports to it, one per cycle. Each report carries severity class flags (uncorrected-urgent, uncorrected-deferred, corrected), a priority, an error code, an address-info type and a few qualifier bits. The engine decides whether the report starts a fresh record, overwrites the stored one, only marks a repeated occurrence, or is dropped. It keeps the severity history sticky across overwrites and manages a read-in-progress flag on every update.

Alongside the status fields, the engine holds a corrected-error counter with a sticky overflow flag. It accepts a software invalidate strobe and drives a one-cycle platform RAS signal. Per-class two-bit enable fields select whether that signal is raised. Register bus decode and bank-wide summaries live in a parent block, which connects to the status outputs and the invalidate strobe.

Top module: `err_rec_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, every record output, the counter, the overflow flag and the RAS signal read 0.
- R2: A report's severity is taken from its highest set flag: uncorrected-urgent (3) outranks uncorrected-deferred (2), which outranks corrected (1). A report with none of the three flags has severity 0.
- R3: A report of severity at least 1 arriving while the record is invalid is logged in the next cycle. The valid bit goes to 1, read-in-progress goes to 1 and multiple-occurrence goes to 0. The flags are replaced by the report's highest flag only, so a lower flag in the same report is masked. Priority, code, address-info type, containable, timestamp-valid and scrub are copied.
- R4: While the record is valid, a report of higher severity overwrites all copied fields. It ORs its flags into the stored flags, which stay sticky. It clears read-in-progress and leaves multiple-occurrence unchanged.
- R5: While the record is valid, a report of equal severity sets multiple-occurrence and clears read-in-progress. It replaces the copied fields only when its priority is strictly greater than the stored priority.
- R6: While the record is valid, a report of lower severity leaves every record output unchanged.
- R7: Every cycle with a report whose corrected flag is set advances the corrected-error counter by one, whether or not the report is logged. The counter wraps from all ones to zero.
- R8: The wrap of the corrected-error counter sets the overflow flag. The flag then stays set until reset.
- R9: A software invalidate strobe clears the valid bit in the next cycle and leaves the other fields as they are. If a report of severity at least 1 arrives in the same cycle, the strobe is dropped and the report is handled as usual.
- R10: The RAS signal is high for exactly the cycle after a report is written into the record (R3, R4, or R5 with a higher priority). It is raised only when the enable field of that report's class holds 3. The values 0, 1 and 2 raise nothing, and the enable of a class disabled by parameter reads as 0.
- R11: A cycle without a report, or with a report carrying no class flag, changes no record output and raises no RAS signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | An error report is present this cycle |
| rpt_uue | input | 1 | Report flag: uncorrected, urgent |
| rpt_ude | input | 1 | Report flag: uncorrected, deferred |
| rpt_ce | input | 1 | Report flag: corrected |
| rpt_pri | input | PRI_W | Report priority |
| rpt_code | input | EC_W | Report error code |
| rpt_ait | input | AIT_W | Report address-info type |
| rpt_contain | input | 1 | Report is containable |
| rpt_tsv | input | 1 | Report timestamp is valid |
| rpt_scrub | input | 1 | Report came from a scrubber |
| sw_inv | input | 1 | Software invalidate strobe |
| en_ce | input | 2 | Signal enable, corrected class |
| en_ude | input | 2 | Signal enable, deferred class |
| en_uue | input | 2 | Signal enable, urgent class |
| rec_valid | output | 1 | Record holds a valid error |
| rec_uue | output | 1 | Sticky urgent flag |
| rec_ude | output | 1 | Sticky deferred flag |
| rec_ce | output | 1 | Sticky corrected flag |
| rec_mo | output | 1 | Multiple occurrence |
| rec_rdip | output | 1 | Read in progress |
| rec_pri | output | PRI_W | Stored priority |
| rec_code | output | EC_W | Stored error code |
| rec_ait | output | AIT_W | Stored address-info type |
| rec_contain | output | 1 | Stored containable bit |
| rec_tsv | output | 1 | Stored timestamp-valid bit |
| rec_scrub | output | 1 | Stored scrub bit |
| ce_count | output | CEC_W | Corrected-error counter |
| ce_overflow | output | 1 | Sticky counter overflow |
| ras_sig | output | 1 | One-cycle platform RAS signal |

## Verification
The assertions check on every cycle that each update class leaves its mark. A fresh log sets read-in-progress and clears multiple-occurrence. A higher-severity overwrite keeps the earlier flags and clears read-in-progress. An equal-severity report sets multiple-occurrence. Lower-severity and empty reports leave the stored fields alone. The counter steps by one, the overflow flag never drops, and an unopposed invalidate clears the valid bit. A RAS pulse is only ever the echo of a write. The bench scenarios are needed for the outcomes that depend on values: that the right fields are copied, the strict priority tie-break, the masking of lower flags on a fresh log, the invalidate-versus-report collision, which enable values raise the signal, and the exact counter wrap after 65536 corrected reports.

// File: rtl/err_rec_pkg.sv
package err_rec_pkg;

  typedef enum logic [1:0] {
    SEV_NONE = 2'd0,
    SEV_CE   = 2'd1,
    SEV_UDE  = 2'd2,
    SEV_UUE  = 2'd3
  } sev_e;

  localparam logic [1:0] SIG_OFF = 2'd0;
  localparam logic [1:0] SIG_RAS = 2'd3;

  // highest set flag wins
  function automatic sev_e sev_of(input logic uue, input logic ude, input logic ce);
    if (uue)      return SEV_UUE;
    else if (ude) return SEV_UDE;
    else if (ce)  return SEV_CE;
    else          return SEV_NONE;
  endfunction

endpackage

// File: rtl/err_rec_decide.sv
module err_rec_decide
  import err_rec_pkg::*;
#(
  parameter int PRI_W = 2
) (
  input  logic             rpt_valid,
  input  logic             rpt_uue,
  input  logic             rpt_ude,
  input  logic             rpt_ce,
  input  logic [PRI_W-1:0] rpt_pri,
  input  logic             cur_valid,
  input  logic             cur_uue,
  input  logic             cur_ude,
  input  logic             cur_ce,
  input  logic [PRI_W-1:0] cur_pri,
  output logic             accept,
  output logic             ev_first,
  output logic             ev_higher,
  output logic             ev_equal,
  output logic             ev_lower,
  output logic             ev_write,
  output sev_e             new_sev
);

  sev_e old_sev;

  always_comb begin
    new_sev   = sev_of(rpt_uue, rpt_ude, rpt_ce);
    old_sev   = sev_of(cur_uue, cur_ude, cur_ce);
    accept    = rpt_valid && (new_sev != SEV_NONE);
    ev_first  = accept && !cur_valid;
    ev_higher = accept && cur_valid && (new_sev > old_sev);
    ev_equal  = accept && cur_valid && (new_sev == old_sev);
    ev_lower  = accept && cur_valid && (new_sev < old_sev);
    ev_write  = ev_first || ev_higher || (ev_equal && (rpt_pri > cur_pri));
  end

endmodule

// File: rtl/err_rec_cec.sv
module err_rec_cec #(
  parameter int CEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CEC_W-1:0] count,
  output logic             ovf
);

  localparam logic [CEC_W-1:0] ONE = CEC_W'(1);

  // {carry, next}
  function automatic logic [CEC_W:0] bump(input logic [CEC_W-1:0] v);
    return {1'b0, v} + {1'b0, ONE};
  endfunction

  logic [CEC_W:0] nxt;
  assign nxt = bump(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (inc) begin
      count <= nxt[CEC_W-1:0];
      if (nxt[CEC_W]) ovf <= 1'b1;
    end
  end

  assert_cec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + ONE);
  assert_cec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_ovf_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> count == '0);

endmodule

// File: rtl/err_rec_sig.sv
module err_rec_sig
  import err_rec_pkg::*;
#(
  parameter bit HAS_CE  = 1'b1,
  parameter bit HAS_UDE = 1'b1,
  parameter bit HAS_UUE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  sev_e       sev,
  input  logic [1:0] en_ce,
  input  logic [1:0] en_ude,
  input  logic [1:0] en_uue,
  output logic       ras_sig
);

  logic [1:0] eff_ce, eff_ude, eff_uue, sel;

  generate
    if (HAS_CE)  begin : g_ce  assign eff_ce  = en_ce;  end
    else         begin : g_nce assign eff_ce  = SIG_OFF; end
    if (HAS_UDE) begin : g_ude  assign eff_ude = en_ude; end
    else         begin : g_nude assign eff_ude = SIG_OFF; end
    if (HAS_UUE) begin : g_uue  assign eff_uue = en_uue; end
    else         begin : g_nuue assign eff_uue = SIG_OFF; end
  endgenerate

  always_comb begin
    case (sev)
      SEV_UUE: sel = eff_uue;
      SEV_UDE: sel = eff_ude;
      SEV_CE:  sel = eff_ce;
      default: sel = SIG_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ras_sig <= 1'b0;
    else        ras_sig <= fire && (sel == SIG_RAS);
  end

  assert_sig_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ras_sig |-> $past(fire));

endmodule

// File: rtl/err_rec_engine.sv
module err_rec_engine
  import err_rec_pkg::*;
#(
  parameter int PRI_W   = 2,
  parameter int EC_W    = 8,
  parameter int AIT_W   = 4,
  parameter int CEC_W   = 16,
  parameter bit HAS_CE  = 1'b1,
  parameter bit HAS_UDE = 1'b1,
  parameter bit HAS_UUE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rpt_valid,
  input  logic             rpt_uue,
  input  logic             rpt_ude,
  input  logic             rpt_ce,
  input  logic [PRI_W-1:0] rpt_pri,
  input  logic [EC_W-1:0]  rpt_code,
  input  logic [AIT_W-1:0] rpt_ait,
  input  logic             rpt_contain,
  input  logic             rpt_tsv,
  input  logic             rpt_scrub,
  input  logic             sw_inv,
  input  logic [1:0]       en_ce,
  input  logic [1:0]       en_ude,
  input  logic [1:0]       en_uue,
  output logic             rec_valid,
  output logic             rec_uue,
  output logic             rec_ude,
  output logic             rec_ce,
  output logic             rec_mo,
  output logic             rec_rdip,
  output logic [PRI_W-1:0] rec_pri,
  output logic [EC_W-1:0]  rec_code,
  output logic [AIT_W-1:0] rec_ait,
  output logic             rec_contain,
  output logic             rec_tsv,
  output logic             rec_scrub,
  output logic [CEC_W-1:0] ce_count,
  output logic             ce_overflow,
  output logic             ras_sig
);

  // named internal events, shared with the assertions
  logic accept, ev_first, ev_higher, ev_equal, ev_lower, ev_write;
  logic inv_taken;
  sev_e new_sev;

  err_rec_decide #(.PRI_W(PRI_W)) u_decide (
    .rpt_valid (rpt_valid),
    .rpt_uue   (rpt_uue),
    .rpt_ude   (rpt_ude),
    .rpt_ce    (rpt_ce),
    .rpt_pri   (rpt_pri),
    .cur_valid (rec_valid),
    .cur_uue   (rec_uue),
    .cur_ude   (rec_ude),
    .cur_ce    (rec_ce),
    .cur_pri   (rec_pri),
    .accept    (accept),
    .ev_first  (ev_first),
    .ev_higher (ev_higher),
    .ev_equal  (ev_equal),
    .ev_lower  (ev_lower),
    .ev_write  (ev_write),
    .new_sev   (new_sev)
  );

  // a report in the same cycle wins over the invalidate strobe
  assign inv_taken = sw_inv && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid   <= 1'b0;
      rec_uue     <= 1'b0;
      rec_ude     <= 1'b0;
      rec_ce      <= 1'b0;
      rec_mo      <= 1'b0;
      rec_rdip    <= 1'b0;
      rec_pri     <= '0;
      rec_code    <= '0;
      rec_ait     <= '0;
      rec_contain <= 1'b0;
      rec_tsv     <= 1'b0;
      rec_scrub   <= 1'b0;
    end else begin
      if (ev_first) begin
        rec_rdip <= 1'b1;
        rec_mo   <= 1'b0;
        rec_uue  <= rpt_uue;
        rec_ude  <= rpt_ude & ~rpt_uue;
        rec_ce   <= rpt_ce & ~rpt_ude & ~rpt_uue;
      end else if (ev_higher) begin
        rec_rdip <= 1'b0;
        rec_uue  <= rec_uue | rpt_uue;
        rec_ude  <= rec_ude | rpt_ude;
        rec_ce   <= rec_ce  | rpt_ce;
      end else if (ev_equal) begin
        rec_mo   <= 1'b1;
        rec_rdip <= 1'b0;
      end

      if (ev_write) begin
        rec_valid   <= 1'b1;
        rec_pri     <= rpt_pri;
        rec_code    <= rpt_code;
        rec_ait     <= rpt_ait;
        rec_contain <= rpt_contain;
        rec_tsv     <= rpt_tsv;
        rec_scrub   <= rpt_scrub;
      end else if (inv_taken) begin
        rec_valid <= 1'b0;
      end
    end
  end

  err_rec_cec #(.CEC_W(CEC_W)) u_cec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rpt_valid && rpt_ce),
    .count (ce_count),
    .ovf   (ce_overflow)
  );

  err_rec_sig #(.HAS_CE(HAS_CE), .HAS_UDE(HAS_UDE), .HAS_UUE(HAS_UUE)) u_sig (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (ev_write),
    .sev     (new_sev),
    .en_ce   (en_ce),
    .en_ude  (en_ude),
    .en_uue  (en_uue),
    .ras_sig (ras_sig)
  );

  // R3: fresh log
  assert_first_log_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> rec_valid && rec_rdip && !rec_mo && $onehot0({rec_uue, rec_ude, rec_ce}));
  // R4: sticky history on higher severity
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_higher |=> !rec_rdip && rec_valid
                  && (rec_uue || !$past(rec_uue))
                  && (rec_ude || !$past(rec_ude))
                  && (rec_ce  || !$past(rec_ce)));
  // R5: repeat of equal severity
  assert_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_equal |=> rec_mo && !rec_rdip && rec_valid);
  // R6: lower severity leaves record alone
  assert_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lower |=> $stable(rec_code) && $stable(rec_pri) && $stable(rec_valid) && $stable(rec_mo));
  // R9: unopposed invalidate
  assert_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_taken |=> !rec_valid);
  // R11: no report, no change
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !sw_inv |=> $stable(rec_valid) && $stable(rec_code) && $stable(rec_uue)
                           && $stable(rec_mo) && $stable(rec_rdip) && !ras_sig);

endmodule

// File: tb/err_rec_engine_test.sv
module err_rec_engine_test;
  localparam int PW = 2;
  localparam int EW = 8;
  localparam int AW = 4;
  localparam int CW = 16;
  localparam int VW = 6 + PW + EW + AW + 3 + CW + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          rpt_valid, rpt_uue, rpt_ude, rpt_ce;
  logic [PW-1:0] rpt_pri;
  logic [EW-1:0] rpt_code;
  logic [AW-1:0] rpt_ait;
  logic          rpt_contain, rpt_tsv, rpt_scrub, sw_inv;
  logic [1:0]    en_ce, en_ude, en_uue;
  logic          rec_valid, rec_uue, rec_ude, rec_ce, rec_mo, rec_rdip;
  logic [PW-1:0] rec_pri;
  logic [EW-1:0] rec_code;
  logic [AW-1:0] rec_ait;
  logic          rec_contain, rec_tsv, rec_scrub;
  logic [CW-1:0] ce_count;
  logic          ce_overflow, ras_sig;

  err_rec_engine uut (
    .clk(clk), .rst_n(rst_n),
    .rpt_valid(rpt_valid), .rpt_uue(rpt_uue), .rpt_ude(rpt_ude), .rpt_ce(rpt_ce),
    .rpt_pri(rpt_pri), .rpt_code(rpt_code), .rpt_ait(rpt_ait),
    .rpt_contain(rpt_contain), .rpt_tsv(rpt_tsv), .rpt_scrub(rpt_scrub),
    .sw_inv(sw_inv), .en_ce(en_ce), .en_ude(en_ude), .en_uue(en_uue),
    .rec_valid(rec_valid), .rec_uue(rec_uue), .rec_ude(rec_ude), .rec_ce(rec_ce),
    .rec_mo(rec_mo), .rec_rdip(rec_rdip), .rec_pri(rec_pri), .rec_code(rec_code),
    .rec_ait(rec_ait), .rec_contain(rec_contain), .rec_tsv(rec_tsv),
    .rec_scrub(rec_scrub), .ce_count(ce_count), .ce_overflow(ce_overflow),
    .ras_sig(ras_sig)
  );

  typedef struct {
    logic [VW-1:0] vec;
    string         tag;
  } item_t;
  item_t q[$];

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model of the record
  logic          m_v = 0, m_uue = 0, m_ude = 0, m_ce = 0, m_mo = 0, m_rdip = 0;
  logic [PW-1:0] m_pri = '0;
  logic [EW-1:0] m_code = '0;
  logic [AW-1:0] m_ait = '0;
  logic          m_c = 0, m_tsv = 0, m_scrub = 0, m_ovf = 0, m_sig = 0;
  logic [CW-1:0] m_cnt = '0;
  logic [1:0]    b_en_ce = 0, b_en_ude = 0, b_en_uue = 0;

  function automatic int rank(input logic u, input logic d, input logic c);
    int r = 0;
    if (c) r = 1;
    if (d) r = 2;
    if (u) r = 3;
    return r;
  endfunction

  function automatic logic [VW-1:0] model_vec();
    return {m_v, m_uue, m_ude, m_ce, m_mo, m_rdip, m_pri, m_code, m_ait,
            m_c, m_tsv, m_scrub, m_cnt, m_ovf, m_sig};
  endfunction

  function automatic logic [VW-1:0] dut_vec();
    return {rec_valid, rec_uue, rec_ude, rec_ce, rec_mo, rec_rdip, rec_pri, rec_code,
            rec_ait, rec_contain, rec_tsv, rec_scrub, ce_count, ce_overflow, ras_sig};
  endfunction

  task automatic step(input logic v, input logic u, input logic d, input logic c,
                      input logic [PW-1:0] pri, input logic [EW-1:0] code,
                      input logic [AW-1:0] ait, input logic cn, input logic ts,
                      input logic sc, input logic inv, input string tag);
    int ns, os;
    logic wr;
    logic [1:0] e;
    item_t it;
    @(negedge clk);
    rpt_valid = v; rpt_uue = u; rpt_ude = d; rpt_ce = c; rpt_pri = pri;
    rpt_code = code; rpt_ait = ait; rpt_contain = cn; rpt_tsv = ts;
    rpt_scrub = sc; sw_inv = inv;
    en_ce = b_en_ce; en_ude = b_en_ude; en_uue = b_en_uue;
    ns = rank(u, d, c);
    os = rank(m_uue, m_ude, m_ce);
    wr = 0;
    m_sig = 0;
    if (v && ns != 0) begin
      if (!m_v) begin
        m_rdip = 1; m_mo = 0; m_uue = u; m_ude = d && !u; m_ce = c && !d && !u; wr = 1;
      end else if (ns > os) begin
        m_rdip = 0; m_uue = m_uue | u; m_ude = m_ude | d; m_ce = m_ce | c; wr = 1;
      end else if (ns == os) begin
        m_mo = 1; m_rdip = 0;
        if (pri > m_pri) wr = 1;
      end
      if (wr) begin
        m_v = 1; m_pri = pri; m_code = code; m_ait = ait; m_c = cn; m_tsv = ts; m_scrub = sc;
        e = (ns == 3) ? b_en_uue : ((ns == 2) ? b_en_ude : b_en_ce);
        m_sig = (e == 2'd3);
      end
    end else if (inv) begin
      m_v = 0;
    end
    if (v && c) begin
      if (m_cnt == {CW{1'b1}}) m_ovf = 1;
      m_cnt = m_cnt + 1'b1;
    end
    it.vec = model_vec();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compares one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (dut_vec() !== it.vec) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, dut_vec(), it.vec);
        end
      end
    end
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    rpt_valid = 0; rpt_uue = 0; rpt_ude = 0; rpt_ce = 0; rpt_pri = '0; rpt_code = '0;
    rpt_ait = '0; rpt_contain = 0; rpt_tsv = 0; rpt_scrub = 0; sw_inv = 0;
    en_ce = 0; en_ude = 0; en_uue = 0;
    repeat (3) @(negedge clk);
    #1;
    if ({rec_valid, rec_mo, rec_rdip, ce_count, ce_overflow, ras_sig} !== '0) begin
      n_fail++;
      $display("FAIL R1: actual %h expected 0", dut_vec());
    end
    n_chk++;
    rst_n = 1;
    idle("R1 after reset");

    // R3 fresh corrected log, ras enabled for CE
    b_en_ce = 2'd3;
    step(1, 0, 0, 1, 2'd1, 8'h11, 4'h2, 1, 0, 1, 0, "R3 R7 R10 first CE log");
    idle("R10 pulse is one cycle");
    // R5 equal severity, lower priority: mo only
    step(1, 0, 0, 1, 2'd0, 8'h22, 4'h3, 0, 1, 0, 0, "R5 equal no overwrite");
    step(1, 0, 0, 1, 2'd1, 8'h23, 4'h3, 0, 1, 0, 0, "R5 equal priority tie");
    step(1, 0, 0, 1, 2'd2, 8'h33, 4'h5, 0, 1, 0, 0, "R5 equal higher priority");
    // R4 higher severity, UDE enable 0
    b_en_ude = 2'd0;
    step(1, 0, 1, 0, 2'd0, 8'h44, 4'h6, 1, 0, 0, 0, "R2 R4 UDE over CE");
    // R6 lower severity
    step(1, 0, 0, 1, 2'd3, 8'h55, 4'h7, 1, 1, 1, 0, "R6 lower ignored");
    // R4 urgent with deferred, enable 3
    b_en_uue = 2'd3;
    step(1, 1, 1, 0, 2'd1, 8'h66, 4'h8, 0, 1, 1, 0, "R2 R4 R10 UUE over UDE");
    // R11 empty report and no report, with the same enable
    step(1, 0, 0, 0, 2'd3, 8'h77, 4'h9, 1, 1, 1, 0, "R11 flagless report");
    idle("R11 idle");
    // R9 invalidate
    step(0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 1, "R9 invalidate");
    // R9 collision: report wins; R3 masks lower flag
    b_en_uue = 2'd1;
    step(1, 1, 1, 1, 2'd0, 8'h88, 4'hA, 1, 0, 0, 1, "R9 R3 report beats invalidate");
    step(0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 1, "R9 invalidate again");
    b_en_ude = 2'd2;
    step(1, 0, 1, 0, 2'd2, 8'h99, 4'hB, 0, 0, 1, 0, "R10 enable 2 silent");
    // R6 lower CE while UDE held, counts only
    b_en_ce = 2'd0;
    // R7 run counter to all ones, R8 wrap
    while (m_cnt != {CW{1'b1}}) step(1, 0, 0, 1, 2'd0, 8'h01, 4'h1, 0, 0, 0, 0, "R7 count");
    step(1, 0, 0, 1, 2'd0, 8'h02, 4'h1, 0, 0, 0, 0, "R7 R8 wrap");
    step(1, 0, 0, 1, 2'd0, 8'h03, 4'h1, 0, 0, 0, 0, "R8 sticky");
    idle("R8 hold");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule